// File: doc/BRIEF.md
# Trigger Memorization Manager

This block sits between a hardware trigger line and a transfer engine. It decides what happens to each rising edge of the trigger. If the engine is idle, the edge starts a transfer at once. If a transfer is already requested or running, the edge is held in a single pending slot. If that slot is already full, the edge is dropped and a sticky overrun flag is raised. When the engine reports that a transfer is done, a held trigger is replayed automatically as the next start request, without waiting for a new edge.

Memorization cannot be switched off. Because of that, the block reports whenever it happens. A sticky flag shows that at least one trigger was held. A saturating counter gives the number of held triggers. Software can use these to find out that samples were delayed, even in runs where no overrun occurred.

The trigger input goes through a parameterized synchronizer and a rising-edge detector. The done input is taken as a single-cycle pulse in the block's clock domain.

Top module: `trig_memo_mgr`

## Requirements
- R1: A trigger rising edge that arrives while no transfer is active raises `start_o` for exactly one cycle. If `trig_i` is first sampled high at clock edge k, `start_o` is high in the cycle after edge k+SYNC_STAGES, and `active_o` goes high with it.
- R2: A trigger edge that arrives while a transfer is active and the slot is empty sets `pending_o` and issues no start.
- R3: A trigger edge that arrives while the slot is full and no done pulse comes in the same cycle sets `ovr_o`. `pending_o` stays 1 and no start is issued.
- R4: A done pulse while the slot is full issues one start, clears `pending_o` and keeps `active_o` high.
- R5: A done pulse while active with an empty slot and no trigger edge lowers `active_o` and issues no start. A done pulse while idle has no effect.
- R6: `ovr_o` stays set until a one-cycle `ovr_clr_i` pulse clears it. If a clear and a new overrun fall in the same cycle, `ovr_o` stays 1.
- R7: Every held trigger increments `memo_cnt_o`, which saturates at 2^CNT_W-1. `memo_seen_o` goes to 1 at the first held trigger and stays 1 until reset.
- R8: While `en_i` is 0, the slot is cleared, trigger edges cause no start, no hold and no overrun, and `ovr_o` keeps its value. A done pulse still ends the active transfer, and a trigger that was held before disable is not replayed.
- R9: If a trigger edge and a done pulse arrive in the same cycle while the slot is full, the held trigger is started, the new edge takes the freed slot, `pending_o` stays 1, no overrun is raised and `memo_cnt_o` increments.
- R10: After reset, `start_o`, `pending_o`, `active_o`, `ovr_o`, `memo_seen_o` and `memo_cnt_o` are all 0.
- R11: A trigger input that is held high for several cycles counts as one edge and yields at most one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable; while low the slot is cleared and triggers are ignored |
| trig_i | input | 1 | Hardware trigger line; a rising edge is an event |
| eng_done_i | input | 1 | One-cycle pulse from the engine when a transfer ends |
| ovr_clr_i | input | 1 | One-cycle pulse that clears the overrun flag |
| start_o | output | 1 | One-cycle start request to the engine |
| active_o | output | 1 | A transfer has been requested and is not yet done |
| pending_o | output | 1 | The single slot holds a memorized trigger |
| ovr_o | output | 1 | Sticky trigger-overrun flag |
| memo_seen_o | output | 1 | Sticky: at least one trigger was memorized |
| memo_cnt_o | output | CNT_W | Saturating count of memorized triggers |

## Verification
The assertions take for granted that `eng_done_i` pulses for one cycle, and only while a transfer this block started is still active. They also assume that `ovr_clr_i` is a single-cycle pulse in the block's clock domain. The directed stimulus keeps to these rules. It raises done only after a start and lowers it at the next falling edge. For the coincidence cases, it places the trigger edge, the done pulse and the clear pulse in the same cycle by counting the synchronizer latency.

// File: rtl/trig_memo_pkg.sv
`timescale 1ns/1ps
// Package: shared event record passed from the slot controller to the status
// logic. Assumes at most one of fire/replay/trash per cycle; memo may pair
// with replay when a new edge takes the slot freed in the same cycle.
package trig_memo_pkg;

    typedef struct packed {
        logic fire;    // edge started a transfer directly
        logic replay;  // held trigger started a transfer
        logic memo;    // edge was placed in the slot
        logic trash;   // edge dropped, overrun
    } trig_evt_t;

    localparam trig_evt_t TRIG_EVT_NONE = '0;

endpackage

// File: rtl/trig_edge_det.sv
`timescale 1ns/1ps
// Module: trig_edge_det
// Synchronizes the trigger line through SYNC_STAGES flops (0 = already
// synchronous) and gives a one-cycle pulse on each rising edge.
// Assumes trig_i stays low for at least one cycle between edges.
module trig_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic edge_o
);

    logic synced;
    logic prev_q;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign synced = trig_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;
            // Purpose: shift the raw trigger through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0] , trig_i} >> 0;
            end
            assign synced = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    // Purpose: remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= synced;
    end

    assign edge_o = synced & ~prev_q;

    // R11
    single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);

endmodule

// File: rtl/trig_slot_ctrl.sv
`timescale 1ns/1ps
// Module: trig_slot_ctrl
// Decides the fate of each trigger edge: fire, memorize into the single slot,
// or trash. Replays the held trigger on the engine's done pulse.
// Assumes done_i is a one-cycle pulse that only comes while a transfer is active.
module trig_slot_ctrl
    import trig_memo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      edge_i,
    input  logic      done_i,
    output logic      start_o,
    output logic      active_o,
    output logic      pending_o,
    output trig_evt_t evt_o
);

    logic active_q, pending_q, start_q;
    logic active_d, pending_d, start_d;
    trig_evt_t evt;

    // Purpose: next-state decision for one trigger/done cycle.
    always_comb begin
        evt       = TRIG_EVT_NONE;
        active_d  = active_q;
        pending_d = pending_q;
        start_d   = 1'b0;
        if (!en_i) begin
            pending_d = 1'b0;
            if (done_i) active_d = 1'b0;
        end else if (done_i && active_q) begin
            if (pending_q) begin
                evt.replay = 1'b1;
                start_d    = 1'b1;
                pending_d  = edge_i;
                evt.memo   = edge_i;
            end else if (edge_i) begin
                evt.fire = 1'b1;
                start_d  = 1'b1;
            end else begin
                active_d = 1'b0;
            end
        end else if (edge_i) begin
            if (!active_q) begin
                evt.fire = 1'b1;
                start_d  = 1'b1;
                active_d = 1'b1;
            end else if (!pending_q) begin
                evt.memo  = 1'b1;
                pending_d = 1'b1;
            end else begin
                evt.trash = 1'b1;
            end
        end
    end

    // Purpose: register transfer state, slot and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            pending_q <= 1'b0;
            start_q   <= 1'b0;
        end else begin
            active_q  <= active_d;
            pending_q <= pending_d;
            start_q   <= start_d;
        end
    end

    assign start_o   = start_q;
    assign active_o  = active_q;
    assign pending_o = pending_q;
    assign evt_o     = evt;

    // R2
    pending_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q |-> active_q);
    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!pending_q && !start_q));
    // R4
    replay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && done_i && pending_q) |=> (start_q && active_q));
    // R3
    trash_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && edge_i && pending_q && !done_i) |=> (pending_q && !start_q));

endmodule

// File: rtl/trig_status.sv
`timescale 1ns/1ps
// Module: trig_status
// Keeps the sticky overrun flag, the sticky memorized flag and the saturating
// count of memorized triggers. Assumes clr_i is a one-cycle pulse.
module trig_status
    import trig_memo_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  trig_evt_t        evt_i,
    input  logic             clr_i,
    output logic             ovr_o,
    output logic             seen_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             ovr_q, seen_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: overrun flag, new overrun wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           ovr_q <= 1'b0;
        else if (evt_i.trash) ovr_q <= 1'b1;
        else if (clr_i)       ovr_q <= 1'b0;
    end

    // Purpose: memorization flag and saturating counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (evt_i.memo) begin
            seen_q <= 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ovr_o  = ovr_q;
    assign seen_o = seen_q;
    assign cnt_o  = cnt_q;

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_i) |=> ovr_q);
    // R7
    seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> seen_q);
    // R7
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/trig_memo_mgr.sv
`timescale 1ns/1ps
// Module: trig_memo_mgr (top)
// Trigger manager with a one-deep memorization slot placed in front of a
// transfer engine. Assumes eng_done_i and ovr_clr_i are synchronous pulses.
module trig_memo_mgr
    import trig_memo_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             trig_i,
    input  logic             eng_done_i,
    input  logic             ovr_clr_i,
    output logic             start_o,
    output logic             active_o,
    output logic             pending_o,
    output logic             ovr_o,
    output logic             memo_seen_o,
    output logic [CNT_W-1:0] memo_cnt_o
);

    logic      trig_edge;
    trig_evt_t evt;

    trig_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .edge_o (trig_edge)
    );

    trig_slot_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .edge_i    (trig_edge),
        .done_i    (eng_done_i),
        .start_o   (start_o),
        .active_o  (active_o),
        .pending_o (pending_o),
        .evt_o     (evt)
    );

    trig_status #(.CNT_W(CNT_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .clr_i  (ovr_clr_i),
        .ovr_o  (ovr_o),
        .seen_o (memo_seen_o),
        .cnt_o  (memo_cnt_o)
    );

    // R1
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !eng_done_i) |=> !start_o);

endmodule

// File: tb/tb_trig_memo_mgr.sv
`timescale 1ns/1ps
module tb_trig_memo_mgr;

    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, trig = 1'b0, done = 1'b0, clr = 1'b0;
    logic start, active, pending, ovr, seen;
    logic [CNT_W-1:0] cnt;

    int n_chk = 0, n_fail = 0, n_start = 0;

    always #2.5 clk = ~clk;

    trig_memo_mgr #(.SYNC_STAGES(2), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .trig_i(trig),
        .eng_done_i(done), .ovr_clr_i(clr),
        .start_o(start), .active_o(active), .pending_o(pending),
        .ovr_o(ovr), .memo_seen_o(seen), .memo_cnt_o(cnt)
    );

    always @(negedge clk) if (rst_n && start) n_start++;

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Trigger edge, plus optional done/clear pulses in the cycle the edge reaches the controller.
    task automatic edge_with(input bit with_done, input bit with_clr);
        trig = 1'b1; step();
        trig = 1'b0; step();
        done = with_done; clr = with_clr; step();
        done = 1'b0; clr = 1'b0;
    endtask

    task automatic trig_pulse();
        edge_with(1'b0, 1'b0);
    endtask

    task automatic done_pulse();
        done = 1'b1; step(); done = 1'b0;
    endtask

    task automatic clr_pulse();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R10 start", start, 0);
        chk_eq("R10 active", active, 0);
        chk_eq("R10 pending", pending, 0);
        chk_eq("R10 ovr", ovr, 0);
        chk_eq("R10 seen", seen, 0);
        chk_eq("R10 cnt", cnt, 0);
    endtask

    task automatic t_fire();
        int s0 = n_start;
        trig_pulse();
        chk_eq("R1 start on idle hit", start, 1);
        chk_eq("R1 active", active, 1);
        step();
        chk_eq("R1 single-cycle start", start, 0);
        done_pulse();
        chk_eq("R5 active drops", active, 0);
        chk_eq("R5 no start", start, 0);
        done_pulse(); step();
        chk_eq("R5 idle done ignored", n_start - s0, 1);
        chk_eq("R5 still idle", active, 0);
    endtask

    task automatic t_memo_replay();
        trig_pulse(); step();
        trig_pulse();
        chk_eq("R2 pending set", pending, 1);
        chk_eq("R2 no start", start, 0);
        chk_eq("R7 seen", seen, 1);
        chk_eq("R7 cnt one", cnt, 1);
        done_pulse();
        chk_eq("R4 replay start", start, 1);
        chk_eq("R4 pending cleared", pending, 0);
        chk_eq("R4 still active", active, 1);
        done_pulse();
        chk_eq("R5 active off", active, 0);
    endtask

    task automatic t_trash();
        int s0 = n_start;
        trig_pulse(); trig_pulse(); trig_pulse(); step();
        chk_eq("R3 overrun", ovr, 1);
        chk_eq("R3 pending kept", pending, 1);
        chk_eq("R3 one start only", n_start - s0, 1);
        clr_pulse();
        chk_eq("R6 clear", ovr, 0);
        done_pulse(); done_pulse();
    endtask

    task automatic t_clr_collide();
        trig_pulse(); trig_pulse();
        edge_with(1'b0, 1'b1);
        chk_eq("R6 clear with overrun keeps flag", ovr, 1);
        step();
        chk_eq("R6 stays set", ovr, 1);
        clr_pulse();
        chk_eq("R6 clear later", ovr, 0);
        done_pulse(); done_pulse();
    endtask

    task automatic t_collide();
        int c0;
        trig_pulse(); trig_pulse();
        c0 = cnt;
        edge_with(1'b1, 1'b0);
        chk_eq("R9 start", start, 1);
        chk_eq("R9 pending kept", pending, 1);
        chk_eq("R9 no overrun", ovr, 0);
        chk_eq("R9 cnt increments", cnt, c0 + 1);
        done_pulse();
        chk_eq("R9 replay of new edge", start, 1);
        done_pulse();
        chk_eq("R9 idle after", active, 0);
    endtask

    task automatic t_enable();
        int s0;
        trig_pulse(); trig_pulse(); trig_pulse();
        chk_eq("R8 setup overrun", ovr, 1);
        en = 1'b0; step();
        chk_eq("R8 slot cleared", pending, 0);
        chk_eq("R8 overrun kept", ovr, 1);
        s0 = n_start;
        trig_pulse(); step();
        chk_eq("R8 no start while off", n_start - s0, 0);
        chk_eq("R8 no hold while off", pending, 0);
        en = 1'b1;
        done_pulse(); step();
        chk_eq("R8 done ends transfer", active, 0);
        chk_eq("R8 no replay", n_start - s0, 0);
        clr_pulse();
    endtask

    task automatic t_held();
        int s0 = n_start;
        trig = 1'b1;
        for (int i = 0; i < 6; i++) step();
        trig = 1'b0; step(); step();
        chk_eq("R11 one start for held line", n_start - s0, 1);
        chk_eq("R11 no hold", pending, 0);
        done_pulse();
    endtask

    task automatic t_sat();
        trig_pulse();
        for (int i = 0; i < 20; i++) begin
            trig_pulse();
            done_pulse();
        end
        done_pulse();
        chk_eq("R7 saturated", cnt, (1 << CNT_W) - 1);
        chk_eq("R7 seen kept", seen, 1);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) step();
        t_reset();
        rst_n = 1'b1; en = 1'b1;
        step(); step();
        t_fire();
        t_memo_replay();
        t_trash();
        t_clr_collide();
        t_collide();
        t_enable();
        t_held();
        t_sat();
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule